// File: doc/BRIEF.md
# Three-Wire Register Programming Interface

This block takes a write-only serial stream on three lines: a serial clock, a data line and an active-low enable. It turns the stream into the control registers of a frequency synthesizer. While the enable line is low, each rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When the enable line rises, the word is committed. The final two bits received select one of four targets, and the bits before them are the payload. The four targets are the full status word, a reduced status word, the feedback divider pair (N and A) and the reference divider (R). The payload length depends on the target.

The block refuses to touch anything but the full status word until that word has been written once. It drives the decoded status fields straight to the analog side:

- standby control, with two power-down levels;
- charge-pump polarity;
- charge-pump current step;
- the divider load mode.

The block also gives the divider chain a one-cycle load strobe. In direct mode, the strobe follows every accepted divider word. In synchronous mode, a feedback-divider word only arms a pending load, and the strobe is released when the divider chain reports that its counters have reached zero.

The serial lines are oversampled in the system clock domain, so the serial clock must run several times slower than the system clock.

Top module: `tw_prog_if`

## Requirements
- R1: While `ser_en_i` is low, each rising edge of `ser_clk_i` shifts the level of `ser_dat_i` into the word, first bit sent being the most significant; a rising edge of `ser_en_i` commits the word, and the registers show the new value within a few system cycles.
- R2: The last two bits shifted before the enable rises are the target code: 00 full status, 01 reduced status, 10 divider pair, 11 reference divider.
- R3: The payload widths are 16 bits for full status, 8 for reduced status, 21 for the divider pair and 16 for the reference divider. In the divider-pair payload, N is the upper 14 bits (`n_div_o`) and A is the lower 7 bits (`a_div_o`).
- R4: When more bits than the target needs are shifted, only the last payload-width-plus-two bits count; the earlier bits are dropped.
- R5: Activity on `ser_clk_i` and `ser_dat_i` while `ser_en_i` is high adds no bits and changes no register.
- R6: A word with fewer bits than its target needs is discarded, and `word_err_o` pulses for exactly one cycle.
- R7: Until a full status word has been accepted, words for the reduced status, the divider pair or the reference divider are discarded, and `word_err_o` pulses.
- R8: A reduced status word replaces status bits [7:0] and leaves bits [15:8] as they were.
- R9: Status bit fields: [1:0] standby code, [2] synchronous load enable (`sync_mode_o`), [3] charge-pump invert (`cp_invert_o`), [6:4] current step (`cp_step_o`); after reset the status word is zero.
- R10: Standby code 01 asserts both `pd_core_o` and `pd_inamp_o`; code 10 asserts only `pd_core_o`; codes 00 and 11 assert neither. Words are still accepted in either standby mode.
- R11: With synchronous load off, every accepted divider-pair or reference-divider word produces exactly one `div_load_o` pulse.
- R12: With synchronous load on, a reference-divider word produces no strobe. A divider-pair word arms a load, which produces one `div_load_o` pulse after `div_zero_i` is seen high and is then disarmed.
- R13: An accepted word never pulses `word_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data |
| ser_en_i | input | 1 | Serial enable, low while shifting, rising edge commits |
| div_zero_i | input | 1 | Divider chain reports counters at zero |
| n_div_o | output | 14 | N divide value |
| a_div_o | output | 7 | A divide value |
| r_div_o | output | 16 | R divide value |
| div_load_o | output | 1 | One-cycle load strobe to the divider chain |
| stat_o | output | 16 | Full status word |
| sync_mode_o | output | 1 | Synchronous load enabled |
| cp_invert_o | output | 1 | Charge-pump polarity invert |
| cp_step_o | output | 3 | Charge-pump current step |
| pd_core_o | output | 1 | Power down everything except the serial interface |
| pd_inamp_o | output | 1 | Power down the input amplifiers |
| word_err_o | output | 1 | One-cycle pulse when a committed word is discarded |

## Verification
The bench builds the block with its default widths:

| Parameter | Value |
|-----------|-------|
| N | 14 |
| A | 7 |
| R | 16 |
| Full status | 16 |
| Reduced status | 8 |

With these widths the shift register holds 23 bits, exactly the divider-pair word. A reference-divider word with five leading junk bits fills the register completely, which tests the drop of early bits at its limit. Short words are checked for two targets, and the write-order rule is checked for three. The synchronous arm-and-release path is checked with a repeated zero report, to show that a load is released only once.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;

    typedef enum logic [1:0] {
        TGT_STAT  = 2'b00,
        TGT_RSTAT = 2'b01,
        TGT_NA    = 2'b10,
        TGT_R     = 2'b11
    } tw_target_e;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'b00,
        PWR_DEEP  = 2'b01,
        PWR_LIGHT = 2'b10,
        PWR_RUN2  = 2'b11
    } tw_power_e;

    localparam int STBY_LSB = 0;
    localparam int SYNC_BIT = 2;
    localparam int INV_BIT  = 3;
    localparam int STEP_LSB = 4;
    localparam int STEP_W   = 3;
    localparam int ADDR_W   = 2;

endpackage

// File: rtl/tw_serial_rx.sv
module tw_serial_rx #(
    parameter int SHIFT_W = 23,
    parameter int CNT_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_en_i,
    output logic               commit_o,
    output logic [SHIFT_W-1:0] word_o,
    output logic [CNT_W-1:0]   cnt_o
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SHIFT_W + 1);

    typedef struct packed {
        logic               clk1;
        logic               clk2;
        logic               dat1;
        logic               en1;
        logic               en2;
        logic [SHIFT_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } rx_state_t;

    rx_state_t rx_q, rx_d;
    logic      en_fall, clk_rise;
    logic [SHIFT_W-1:0] base_sh;
    logic [CNT_W-1:0]   base_cnt;

    always_comb begin
        rx_d      = rx_q;
        rx_d.clk1 = ser_clk_i;
        rx_d.clk2 = rx_q.clk1;
        rx_d.dat1 = ser_dat_i;
        rx_d.en1  = ser_en_i;
        rx_d.en2  = rx_q.en1;

        en_fall  = !rx_q.en1 && rx_q.en2;
        clk_rise = rx_q.clk1 && !rx_q.clk2;

        base_sh  = en_fall ? '0 : rx_q.sh;
        base_cnt = en_fall ? '0 : rx_q.cnt;

        rx_d.sh  = base_sh;
        rx_d.cnt = base_cnt;

        if (!rx_q.en1 && clk_rise) begin
            rx_d.sh  = {base_sh[SHIFT_W-2:0], rx_q.dat1};
            rx_d.cnt = (base_cnt == CNT_SAT) ? base_cnt : base_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q      <= '0;
            rx_q.en1  <= 1'b1;
            rx_q.en2  <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign commit_o = rx_q.en1 && !rx_q.en2;
    assign word_o   = rx_q.sh;
    assign cnt_o    = rx_q.cnt;

    // R5: with enable held high the word and count stay frozen
    a_r5_idle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_q.en1 && rx_q.en2) |=> ($stable(rx_q.sh) && $stable(rx_q.cnt)));

    // R1: the bit count never exceeds its saturation point
    a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_q.cnt <= CNT_SAT);

endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
    import tw_prog_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int RSTAT_W = 8,
    parameter int N_W     = 14,
    parameter int A_W     = 7,
    parameter int R_W     = 16,
    parameter int SHIFT_W = 23,
    parameter int CNT_W   = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               commit_i,
    input  logic [SHIFT_W-1:0] word_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic [N_W-1:0]     n_o,
    output logic [A_W-1:0]     a_o,
    output logic [R_W-1:0]     r_o,
    output logic               err_o,
    output logic               acc_na_o,
    output logic               acc_r_o
);

    localparam int NA_W      = N_W + A_W;
    localparam int LEN_STAT  = STAT_W + ADDR_W;
    localparam int LEN_RSTAT = RSTAT_W + ADDR_W;
    localparam int LEN_NA    = NA_W + ADDR_W;
    localparam int LEN_R     = R_W + ADDR_W;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [N_W-1:0]    n;
        logic [A_W-1:0]    a;
        logic [R_W-1:0]    r;
        logic              seen;
        logic              err;
        logic              acc_na;
        logic              acc_r;
    } bank_state_t;

    bank_state_t bk_q, bk_d;
    tw_target_e  tgt;
    int          need_len;
    logic        long_enough;

    always_comb begin
        tgt = tw_target_e'(word_i[ADDR_W-1:0]);
        case (tgt)
            TGT_STAT:  need_len = LEN_STAT;
            TGT_RSTAT: need_len = LEN_RSTAT;
            TGT_NA:    need_len = LEN_NA;
            default:   need_len = LEN_R;
        endcase
        long_enough = (32'(cnt_i) >= need_len);
    end

    always_comb begin
        bk_d        = bk_q;
        bk_d.err    = 1'b0;
        bk_d.acc_na = 1'b0;
        bk_d.acc_r  = 1'b0;

        if (commit_i) begin
            if (!long_enough) begin
                bk_d.err = 1'b1;
            end else begin
                case (tgt)
                    TGT_STAT: begin
                        bk_d.stat = word_i[STAT_W+ADDR_W-1:ADDR_W];
                        bk_d.seen = 1'b1;
                    end
                    TGT_RSTAT: begin
                        if (!bk_q.seen) begin
                            bk_d.err = 1'b1;
                        end else begin
                            bk_d.stat[RSTAT_W-1:0] = word_i[RSTAT_W+ADDR_W-1:ADDR_W];
                        end
                    end
                    TGT_NA: begin
                        if (!bk_q.seen) begin
                            bk_d.err = 1'b1;
                        end else begin
                            bk_d.n      = word_i[NA_W+ADDR_W-1:A_W+ADDR_W];
                            bk_d.a      = word_i[A_W+ADDR_W-1:ADDR_W];
                            bk_d.acc_na = 1'b1;
                        end
                    end
                    default: begin
                        if (!bk_q.seen) begin
                            bk_d.err = 1'b1;
                        end else begin
                            bk_d.r     = word_i[R_W+ADDR_W-1:ADDR_W];
                            bk_d.acc_r = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign stat_o   = bk_q.stat;
    assign n_o      = bk_q.n;
    assign a_o      = bk_q.a;
    assign r_o      = bk_q.r;
    assign err_o    = bk_q.err;
    assign acc_na_o = bk_q.acc_na;
    assign acc_r_o  = bk_q.acc_r;

    // R7: divider values cannot move before a full status word is accepted
    a_r7_status_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bk_q.seen |=> (n_o == $past(n_o) && a_o == $past(a_o) && r_o == $past(r_o)));

    // R6: the discard flag is a single-cycle pulse
    a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o);

    // R13: an accepted divider word never comes with a discard flag
    a_r13_acc_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_na_o || acc_r_o) |-> !err_o);

endmodule

// File: rtl/tw_load_ctrl.sv
module tw_load_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_en_i,
    input  logic acc_na_i,
    input  logic acc_r_i,
    input  logic div_zero_i,
    output logic load_o
);

    typedef struct packed {
        logic armed;
        logic load;
    } ld_state_t;

    ld_state_t ld_q, ld_d;

    always_comb begin
        ld_d      = ld_q;
        ld_d.load = 1'b0;
        if (!sync_en_i) begin
            ld_d.armed = 1'b0;
            ld_d.load  = acc_na_i || acc_r_i;
        end else begin
            if (ld_q.armed && div_zero_i) begin
                ld_d.load  = 1'b1;
                ld_d.armed = 1'b0;
            end
            if (acc_na_i) begin
                ld_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

    assign load_o = ld_q.load;

    // R11: in direct mode an accepted divider word is followed by the strobe
    a_r11_direct_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_en_i && (acc_na_i || acc_r_i)) |=> load_o);

    // R12: in synchronous mode a strobe only follows a zero report
    a_r12_sync_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_en_i && load_o) |-> $past(div_zero_i));

endmodule

// File: rtl/tw_prog_if.sv
module tw_prog_if
    import tw_prog_pkg::*;
#(
    parameter int STAT_W  = 16,
    parameter int RSTAT_W = 8,
    parameter int N_W     = 14,
    parameter int A_W     = 7,
    parameter int R_W     = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_en_i,
    input  logic               div_zero_i,
    output logic [N_W-1:0]     n_div_o,
    output logic [A_W-1:0]     a_div_o,
    output logic [R_W-1:0]     r_div_o,
    output logic               div_load_o,
    output logic [STAT_W-1:0]  stat_o,
    output logic               sync_mode_o,
    output logic               cp_invert_o,
    output logic [STEP_W-1:0]  cp_step_o,
    output logic               pd_core_o,
    output logic               pd_inamp_o,
    output logic               word_err_o
);

    localparam int NA_W    = N_W + A_W;
    localparam int MAX_AB  = (STAT_W > NA_W) ? STAT_W : NA_W;
    localparam int MAX_CD  = (R_W > RSTAT_W) ? R_W : RSTAT_W;
    localparam int MAX_D   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int SHIFT_W = MAX_D + ADDR_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 2);

    logic               commit;
    logic [SHIFT_W-1:0] word;
    logic [CNT_W-1:0]   cnt;
    logic               acc_na, acc_r;
    tw_power_e          pwr;

    tw_serial_rx #(
        .SHIFT_W (SHIFT_W),
        .CNT_W   (CNT_W)
    ) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ser_clk_i (ser_clk_i),
        .ser_dat_i (ser_dat_i),
        .ser_en_i  (ser_en_i),
        .commit_o  (commit),
        .word_o    (word),
        .cnt_o     (cnt)
    );

    tw_reg_bank #(
        .STAT_W  (STAT_W),
        .RSTAT_W (RSTAT_W),
        .N_W     (N_W),
        .A_W     (A_W),
        .R_W     (R_W),
        .SHIFT_W (SHIFT_W),
        .CNT_W   (CNT_W)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (commit),
        .word_i   (word),
        .cnt_i    (cnt),
        .stat_o   (stat_o),
        .n_o      (n_div_o),
        .a_o      (a_div_o),
        .r_o      (r_div_o),
        .err_o    (word_err_o),
        .acc_na_o (acc_na),
        .acc_r_o  (acc_r)
    );

    tw_load_ctrl u_load (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_en_i  (sync_mode_o),
        .acc_na_i   (acc_na),
        .acc_r_i    (acc_r),
        .div_zero_i (div_zero_i),
        .load_o     (div_load_o)
    );

    always_comb begin
        pwr         = tw_power_e'(stat_o[STBY_LSB +: 2]);
        sync_mode_o = stat_o[SYNC_BIT];
        cp_invert_o = stat_o[INV_BIT];
        cp_step_o   = stat_o[STEP_LSB +: STEP_W];
        pd_core_o   = (pwr == PWR_DEEP) || (pwr == PWR_LIGHT);
        pd_inamp_o  = (pwr == PWR_DEEP);
    end

    // R10: the input amplifiers are never off while the core is on
    a_r10_amp_implies_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_inamp_o |-> pd_core_o);

    // R6: discard flag and load strobe never come from a word in the same cycle
    a_r6_err_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_err_o |=> !div_load_o || sync_mode_o);

endmodule

// File: tb/test_tw_prog_if.sv
module test_tw_prog_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_en = 1'b1;
    logic        div_zero = 1'b0;
    logic [13:0] n_div;
    logic [6:0]  a_div;
    logic [15:0] r_div;
    logic        div_load;
    logic [15:0] stat;
    logic        sync_mode, cp_invert, pd_core, pd_inamp, word_err;
    logic [2:0]  cp_step;

    int checks = 0;
    int errors = 0;
    int errs_seen = 0;
    int loads_seen = 0;

    always #5 clk = ~clk;

    tw_prog_if i_tw_prog_if (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ser_clk_i   (ser_clk),
        .ser_dat_i   (ser_dat),
        .ser_en_i    (ser_en),
        .div_zero_i  (div_zero),
        .n_div_o     (n_div),
        .a_div_o     (a_div),
        .r_div_o     (r_div),
        .div_load_o  (div_load),
        .stat_o      (stat),
        .sync_mode_o (sync_mode),
        .cp_invert_o (cp_invert),
        .cp_step_o   (cp_step),
        .pd_core_o   (pd_core),
        .pd_inamp_o  (pd_inamp),
        .word_err_o  (word_err)
    );

    typedef struct {
        logic [15:0] stat;
        logic [13:0] n;
        logic [6:0]  a;
        logic [15:0] r;
        int          errs;
        int          loads;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    event ev_chk;

    logic [15:0] m_stat = '0;
    logic [13:0] m_n = '0;
    logic [6:0]  m_a = '0;
    logic [15:0] m_r = '0;

    always @(posedge clk) begin
        if (word_err) errs_seen++;
        if (div_load) loads_seen++;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop the expected item and compare against the ports
    initial begin
        forever begin
            @(ev_chk);
            if (sb_q.size() == 0) begin
                check("R1", "scoreboard empty", 64'd0, 64'd1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, "status", 64'(stat), 64'(e.stat));
                check(e.req, "n", 64'(n_div), 64'(e.n));
                check(e.req, "a", 64'(a_div), 64'(e.a));
                check(e.req, "r", 64'(r_div), 64'(e.r));
                check(e.req, "err pulses", 64'(errs_seen), 64'(e.errs));
                check(e.req, "load pulses", 64'(loads_seen), 64'(e.loads));
            end
        end
    end

    task automatic push_and_check(input int exp_errs, input int exp_loads, input string req);
        exp_t e;
        e.stat  = m_stat;
        e.n     = m_n;
        e.a     = m_a;
        e.r     = m_r;
        e.errs  = exp_errs;
        e.loads = exp_loads;
        e.req   = req;
        sb_q.push_back(e);
        -> ev_chk;
        @(negedge clk);
    endtask

    task automatic shift_word(input logic [63:0] v, input int nb);
        @(negedge clk);
        ser_en = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = nb - 1; i >= 0; i--) begin
            ser_dat = v[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
        ser_en = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int nb,
                        input int exp_errs, input int exp_loads, input string req);
        @(negedge clk);
        errs_seen  = 0;
        loads_seen = 0;
        shift_word(v, nb);
        push_and_check(exp_errs, exp_loads, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: reset state
        push_and_check(0, 0, "R9");
        check("R9", "pd_core reset", 64'(pd_core), 64'd0);
        check("R9", "word_err reset", 64'(word_err), 64'd0);

        // R7: writes ahead of the full status word are refused
        send({14'h1234, 7'h55, 2'b10}, 23, 1, 0, "R7");
        send({16'hBEEF, 2'b11}, 18, 1, 0, "R7");
        send({8'h2D, 2'b01}, 10, 1, 0, "R7");

        // R6: short status word refused, status still not seen
        send({10'h3FF, 2'b00}, 12, 1, 0, "R6");

        // R2/R3/R9/R13: full status, direct mode, invert on, step 5
        m_stat = 16'hA558;
        send({16'hA558, 2'b00}, 18, 0, 0, "R2");
        check("R9", "cp_step", 64'(cp_step), 64'd5);
        check("R9", "cp_invert", 64'(cp_invert), 64'd1);
        check("R9", "sync_mode", 64'(sync_mode), 64'd0);
        check("R10", "pd_core run", 64'(pd_core), 64'd0);

        // R3/R11: divider pair in direct mode gives one strobe
        m_n = 14'h1234;
        m_a = 7'h55;
        send({14'h1234, 7'h55, 2'b10}, 23, 0, 1, "R11");

        // R11/R1: reference divider gives one strobe
        m_r = 16'hBEEF;
        send({16'hBEEF, 2'b11}, 18, 0, 1, "R11");

        // R6: short reference divider word
        send({8'hFF, 2'b11}, 10, 1, 0, "R6");

        // R4: extra leading bits dropped
        m_r = 16'h3C5A;
        send({5'b10110, 16'h3C5A, 2'b11}, 23, 0, 1, "R4");

        // R5: toggling with enable high changes nothing
        @(negedge clk);
        errs_seen  = 0;
        loads_seen = 0;
        for (int i = 0; i < 12; i++) begin
            ser_dat = i[0];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (6) @(negedge clk);
        push_and_check(0, 0, "R5");

        // R8/R10: reduced status 0x2D -> standby code 01, sync on, invert on, step 2
        m_stat = 16'hA52D;
        send({8'h2D, 2'b01}, 10, 0, 0, "R8");
        check("R10", "pd_core deep", 64'(pd_core), 64'd1);
        check("R10", "pd_inamp deep", 64'(pd_inamp), 64'd1);
        check("R9", "cp_step", 64'(cp_step), 64'd2);

        // R10/R12: accepted in standby, sync mode, no strobe for reference divider
        m_r = 16'h0102;
        send({16'h0102, 2'b11}, 18, 0, 0, "R12");

        // R12: divider pair only arms
        m_n = 14'h0ABC;
        m_a = 7'h11;
        send({14'h0ABC, 7'h11, 2'b10}, 23, 0, 0, "R12");

        // R12: zero report releases a single strobe
        @(negedge clk);
        errs_seen  = 0;
        loads_seen = 0;
        div_zero = 1'b1;
        @(negedge clk);
        div_zero = 1'b0;
        repeat (4) @(negedge clk);
        push_and_check(0, 1, "R12");

        // R12: second zero report does nothing after disarm
        errs_seen  = 0;
        loads_seen = 0;
        div_zero = 1'b1;
        @(negedge clk);
        div_zero = 1'b0;
        repeat (4) @(negedge clk);
        push_and_check(0, 0, "R12");

        // R10: standby code 10 keeps input amplifiers on
        m_stat = 16'hA50E;
        send({8'h0E, 2'b01}, 10, 0, 0, "R10");
        check("R10", "pd_core light", 64'(pd_core), 64'd1);
        check("R10", "pd_inamp light", 64'(pd_inamp), 64'd0);

        // R10: standby code 11 is running
        m_stat = 16'hA503;
        send({8'h03, 2'b01}, 10, 0, 0, "R10");
        check("R10", "pd_core code3", 64'(pd_core), 64'd0);
        check("R10", "pd_inamp code3", 64'(pd_inamp), 64'd0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule